// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block performs one external memory access at a time for a small CPU with a 16-bit address. The CPU offers a request on a valid/ready handshake. Each request is an instruction fetch, a data read or a data write, with an address and a write byte. The controller then runs the access on an 8-bit bus that carries first the low address byte and then the data. The high address byte has its own dedicated output. When the access ends, the controller gives a one-clock done pulse with the captured byte.

Every access opens with an address-latch strobe, which external logic uses to capture the low address byte. One of three strobes follows: the fetch strobe, the read strobe or the write strobe. A ready input lets a slow device stretch the strobe one clock at a time. An external-access pin decides where fetches go. When the pin is high, fetches are served internally and the bus stays quiet. A configuration pin decides whether the strobe pads are driven high or released while reset is active.

The request side follows these back-pressure rules. `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While an access is in progress, requests are not taken and their fields have no effect. The response side has no back-pressure: `rsp_valid` is a single-clock pulse that the CPU must take when it occurs.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst_n` is low, `ale_n`, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `a_hi` is 0 and `req_ready` is 0.
- R2: While `rst_n` is low, `strobe_oe` equals `flt_cfg`. After reset is released, `strobe_oe` is 1.
- R3: `req_ready` is 1 only when the controller is idle. A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_kind` encoding: 0 = fetch, 1 = read, 2 = write, 3 = read. Requests offered while the controller is busy are ignored.
- R4: For an external access, `ale_n` is low for exactly the 2 clocks that follow acceptance. During those clocks `ad_oe` is 1 and `ad_o` = address[7:0]. `a_hi` = address[15:8] from the first of those clocks on, and it holds that value until the next external access.
- R5: Right after `ale_n` rises, the strobe for the request kind goes low: `psen_n` for a fetch, `rd_n` for a read, `wr_n` for a write. It stays low for 3 clocks when no wait states are added. The other two strobes stay high.
- R6: `bus_ready` is sampled at the edge that ends the last strobe clock. Each sample taken while it is low adds one more strobe clock.
- R7: On a write, `ad_oe` is 1 with `ad_o` = write data from the first strobe clock through the clock after `wr_n` rises.
- R8: On a read or fetch, `ad_oe` is 0 while the strobe is low. `rsp_rdata` is the value of `ad_i` at the edge where the strobe rises.
- R9: `rsp_valid` is high for exactly one clock, the clock right after the strobe rises. `req_ready` returns to 1 on the following clock.
- R10: A fetch taken while `ext_acc_n` is 1 makes no bus activity. It raises `rsp_valid` together with `rsp_internal` in the first clock after acceptance and leaves `a_hi` unchanged. `rsp_internal` is 0 on the done pulse of every external access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (the oscillator period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_cfg | input | 1 | During reset: 1 drives the strobes high, 0 releases them |
| ext_acc_n | input | 1 | 0: fetches use the external bus; 1: fetches are internal |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_internal | output | 1 | Done pulse belongs to an internal fetch |
| rsp_rdata | output | 8 | Byte captured by a read or fetch |
| ad_i | input | 8 | Shared bus input |
| ad_o | output | 8 | Shared bus output (low address or write data) |
| ad_oe | output | 1 | Shared bus output enable |
| a_hi | output | 8 | High address byte |
| ale_n | output | 1 | Address-latch strobe, active low |
| psen_n | output | 1 | Fetch strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Output enable for the four strobe pads |
| bus_ready | input | 1 | Device ready; low stretches the strobe |

## Verification
The sweep runs every access kind, including the alias code 3, against zero to three wait states and several addresses. Each clock of every access is compared with a timeline computed from the wait count. This separates off-by-one errors in the latch phase, the strobe phase and the tail.

`ad_i` carries a decoy value on every clock except the strobe-rising edge, so a capture one edge early or late shows up as a wrong byte. A conflicting request is held on the handshake for the whole access, so any acceptance while busy would disturb the address or the strobe timeline. Internal fetches are placed between external accesses to show that they leave the pins untouched. Both settings of `flt_cfg` are tried during reset.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ALE,
    S_STB,
    S_TAIL,
    S_INT
  } seq_state_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ALE_CLKS = 2,
  parameter int STB_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       ext_acc_n,
  input  logic       bus_ready,
  output seq_state_e state,
  output logic       take,
  output logic       take_int,
  output logic       cap
);
  localparam int MAXC  = (ALE_CLKS > STB_CLKS) ? ALE_CLKS : STB_CLKS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CLKS - 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_CLKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             stb_last;

  assign take     = req_valid && (state == S_IDLE);
  assign take_int = take && (req_kind == KIND_FETCH) && ext_acc_n;
  assign stb_last = (state == S_STB) && (cnt == STB_LAST);
  assign cap      = stb_last && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (take) state <= take_int ? S_INT : S_ALE;
        end
        S_ALE: begin
          if (cnt == ALE_LAST) begin
            state <= S_STB;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STB: begin
          if (cnt != STB_LAST) cnt <= cnt + 1'b1;
          else if (bus_ready)  state <= S_TAIL;
        end
        S_TAIL:  state <= S_IDLE;
        S_INT:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: a low ready on the last strobe clock keeps the strobe phase alive
  a_r6_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_last && !bus_ready) |=> (state == S_STB));

  // R4: the strobe phase is entered only from the latch phase
  a_r4_latch_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_STB) |-> ($past(state) == S_ALE));
endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_int,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              is_fetch,
  output logic              is_write
);
  logic take_ext;
  assign take_ext = take && !take_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      is_fetch <= 1'b0;
      is_write <= 1'b0;
    end else if (take_ext) begin
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      is_fetch <= (req_kind == KIND_FETCH);
      is_write <= (req_kind == KIND_WRITE);
    end
  end

  // R10: an internal fetch leaves the held address alone
  a_r10_int_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> $stable(addr_q));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flt_cfg,
  input  seq_state_e               state,
  input  logic                     cap,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  input  logic                     is_fetch,
  input  logic                     is_write,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale_n,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     strobe_oe,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic                     rsp_internal,
  output logic [DATA_W-1:0]        rsp_rdata
);
  logic in_ale, in_stb, in_tail;

  assign in_ale  = (state == S_ALE);
  assign in_stb  = (state == S_STB);
  assign in_tail = (state == S_TAIL);

  assign ale_n  = !in_ale;
  assign psen_n = !(in_stb && is_fetch);
  assign wr_n   = !(in_stb && is_write);
  assign rd_n   = !(in_stb && !is_fetch && !is_write);

  assign ad_oe = in_ale || (is_write && (in_stb || in_tail));
  assign ad_o  = in_ale ? addr_q[DATA_W-1:0] : wdata_q;
  assign a_hi  = addr_q[ADDR_W-1:DATA_W];

  assign strobe_oe    = rst_n || flt_cfg;
  assign req_ready    = rst_n && (state == S_IDLE);
  assign rsp_valid    = in_tail || (state == S_INT);
  assign rsp_internal = (state == S_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rsp_rdata <= '0;
    else if (cap) rsp_rdata <= ad_i;
  end

  // R5: a data or fetch strobe falls only straight after the latch strobe
  a_r5_strobe_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n) || $fell(psen_n)) |-> $past(!ale_n));

  // R7: the bus is still driven on the clock where the write strobe rises
  a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  // R8: the bus is released whenever a read or fetch strobe is low
  a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  // R9: the done pulse lasts a single clock
  a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: an internal done pulse follows a clock without any latch strobe
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_internal |-> ($past(ale_n) && ale_n && rd_n && wr_n && psen_n));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int ALE_CLKS = 2,
  parameter int STB_CLKS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flt_cfg,
  input  logic                     ext_acc_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_internal,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale_n,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     strobe_oe,
  input  logic                     bus_ready
);
  seq_state_e        state;
  logic              take, take_int, cap;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              is_fetch, is_write;

  xbus_seq #(.ALE_CLKS(ALE_CLKS), .STB_CLKS(STB_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .ext_acc_n(ext_acc_n), .bus_ready(bus_ready), .state(state),
    .take(take), .take_int(take_int), .cap(cap)
  );

  xbus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take), .take_int(take_int),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .addr_q(addr_q), .wdata_q(wdata_q), .is_fetch(is_fetch), .is_write(is_write)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .flt_cfg(flt_cfg), .state(state), .cap(cap),
    .addr_q(addr_q), .wdata_q(wdata_q), .is_fetch(is_fetch), .is_write(is_write),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .a_hi(a_hi), .ale_n(ale_n),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_internal(rsp_internal),
    .rsp_rdata(rsp_rdata)
  );

  // R3: a request is never taken while a done pulse is showing
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_cfg = 1'b1;
  logic        ext_acc_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        rsp_valid, rsp_internal;
  logic [7:0]  rsp_rdata;
  logic [7:0]  ad_i = 8'h0;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [7:0]  a_hi;
  logic        ale_n, psen_n, rd_n, wr_n, strobe_oe;
  logic        bus_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] last_hi = 8'h00;

  always #5 clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .flt_cfg(flt_cfg), .ext_acc_n(ext_acc_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_internal(rsp_internal), .rsp_rdata(rsp_rdata), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe(ad_oe), .a_hi(a_hi), .ale_n(ale_n), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe), .bus_ready(bus_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // pin word: {ale_n,psen_n,rd_n,wr_n,ad_oe,a_hi,rsp_valid,req_ready,strobe_oe}
  function automatic logic [31:0] pins();
    return {16'h0, ale_n, psen_n, rd_n, wr_n, ad_oe, a_hi, rsp_valid, req_ready, strobe_oe};
  endfunction

  function automatic logic [31:0] mk(input logic a, p, r, w, oe, input logic [7:0] hi,
                                     input logic v, rdy, soe);
    return {16'h0, a, p, r, w, oe, hi, v, rdy, soe};
  endfunction

  task automatic ext_xfer(input logic [1:0] kind, input logic [15:0] addr,
                          input logic [7:0] wd, input int waits, input logic [7:0] rv);
    logic is_f, is_w, is_r;
    int last;
    string tag;
    is_f = (kind == 2'd0);
    is_w = (kind == 2'd2);
    is_r = !is_f && !is_w;
    last = 7 + waits;
    @(negedge clk);
    chk("R3 idle ready", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
    ext_acc_n = 1'b0; bus_ready = 1'b1; ad_i = ~rv;
    for (int n = 1; n <= last; n++) begin
      logic stb, a, oe;
      @(negedge clk);
      a   = (n <= 2);
      stb = (n >= 3) && (n <= 5 + waits);
      oe  = a || (is_w && n >= 3 && n <= 6 + waits);
      if (n <= 2) tag = "R4 latch";
      else if (stb) tag = (n > 5) ? "R6 wait" : (is_w ? "R7 write" : "R5 strobe");
      else if (n == 6 + waits) tag = "R9 done";
      else tag = "R9 ready back";
      chk(tag, pins(), mk(!a, !(stb && is_f), !(stb && is_r), !(stb && is_w), oe,
                          addr[15:8], n == 6 + waits, n == last, 1'b1));
      if (oe) chk(is_w && !a ? "R7 wdata" : "R4 low addr", {24'h0, ad_o},
                  {24'h0, (a ? addr[7:0] : wd)});
      if (n == 6 + waits) begin
        chk("R10 ext flag", {31'h0, rsp_internal}, 32'h0);
        if (!is_w) chk("R8 rdata", {24'h0, rsp_rdata}, {24'h0, rv});
      end
      // conflicting request held while busy (R3), dropped before idle
      req_kind = kind ^ 2'd3; req_addr = ~addr; req_wdata = ~wd;
      if (n >= 6 + waits) req_valid = 1'b0;
      bus_ready = !(n >= 5 && (n - 5) < waits);
      ad_i = (n == 5 + waits) ? rv : ~rv;
    end
    last_hi = addr[15:8];
  endtask

  task automatic int_fetch(input logic [15:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_addr = addr; ext_acc_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 int done", pins(), mk(1, 1, 1, 1, 0, last_hi, 1, 0, 1));
    chk("R10 int flag", {31'h0, rsp_internal}, 32'h1);
    @(negedge clk);
    chk("R10 int ready", pins(), mk(1, 1, 1, 1, 0, last_hi, 0, 1, 1));
    ext_acc_n = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 / R2: reset state with both pad choices
    #12;
    chk("R1 reset pins", pins(), mk(1, 1, 1, 1, 0, 8'h00, 0, 0, 1));
    flt_cfg = 1'b0;
    #1;
    chk("R2 float in reset", {31'h0, strobe_oe}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 driven after reset", {31'h0, strobe_oe}, 32'h1);
    for (int k = 0; k < 3; k++)
      for (int w = 0; w < 4; w++)
        for (int i = 0; i < 4; i++) begin
          logic [15:0] ad;
          ad = (16'h1234 * 16'(i + 1)) ^ (16'(k) << 14);
          ext_xfer(2'(k), ad, ad[7:0] + 8'h5A + 8'(w), w, ad[15:8] ^ 8'hC3);
          if (i == 1) int_fetch(~ad);
        end
    ext_xfer(2'd3, 16'hBEEF, 8'h11, 1, 8'h96);   // R3 code 3 acts as read
    int_fetch(16'h0F0F);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule